// File: doc/BRIEF.md
# Parity-Banked Register File with Two Writes and Four Reads

This block is a register file with two write ports and four read ports. It is built only from simple synchronous memories, and each memory has one write port and one read port. The registers are split by the lowest address bit into an even bank and an odd bank, and each bank has one write port. Each bank is copied once for every read port. All copies of a bank take the same write address, data and enable, so they always hold the same data. Each read port gets one copy of each bank and picks between the two outputs using the parity of its address. That parity is registered so that it lines up with the memory's one-cycle read.

Write port A is meant for even registers and write port B for odd ones. The read ports can address any register. A set-select input forms the top address bit of every memory, so it switches between whole register contexts, for example on an interrupt or a task switch. Software is expected to write a register before reading it, because the storage has no reset value.

When the write rules are broken, the block still writes in a defined way and reports the breach. A write on the wrong parity still reaches the bank its address names. When both writes land in one bank, port A wins and port B's write is dropped. In every such case a sticky conflict flag is set, and it stays set until it is cleared.

Top module: `banked_regfile`

## Requirements
- R1: A port-A write to an even address in the current set can be read on all four read ports. The read address is presented on a later cycle, and the data appears one clock edge after that address is sampled.
- R2: Port A can write an even register and port B an odd register in the same cycle. Both values are stored and neither write raises the conflict flag.
- R3: Each read port is independent and can read any register of either parity. Bit 0 of the address selects the bank: 0 is even, 1 is odd. `rd_data` for a port is valid one edge after its `rd_addr` is sampled.
- R4: A read of a register that is being written on the same edge returns the contents it held before that write.
- R5: `set_sel` is sampled at the edge and applies to both writes and reads on that edge. The same register number in different sets is separate storage.
- R6: When both ports are enabled and their addresses have the same bit 0, port A's write is stored and port B's write is dropped. `conflict` reads 1 after that edge.
- R7: When a port writes alone on the wrong parity (A with bit 0 = 1, or B with bit 0 = 0), the write is still stored at its address. `conflict` reads 1 after that edge.
- R8: `conflict` stays at 1 while `conflict_clr` is low. If `conflict_clr` is high in a cycle with no new breach, `conflict` reads 0 after that edge. If a breach happens in the same cycle as the clear, `conflict` stays at 1.
- R9: After reset, `conflict` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| set_sel | input | SET_W (1) | Register set used for reads and writes at this edge |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | ADDR_W (5) | Write port A register number (even expected) |
| wa_data | input | DATA_W (32) | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | ADDR_W (5) | Write port B register number (odd expected) |
| wb_data | input | DATA_W (32) | Write port B data |
| rd_addr | input | NUM_RD x ADDR_W (4x5) | Read address for each read port, packed |
| rd_data | output | NUM_RD x DATA_W (4x32) | Read data for each read port, one cycle after its address |
| conflict_clr | input | 1 | Clears the sticky conflict flag |
| conflict | output | 1 | Sticky flag for a wrong-parity write or a same-bank write collision |

## Verification
Two pairs of functions can fall in the same cycle. The first is a read and a write to the same register. The bench reads a register on the very edge that writes it and expects the old value, then reads it again and expects the new value. The second is a flag clear and a new write breach. The bench drives `conflict_clr` together with a wrong-parity write and expects the flag to stay set. It also drives a same-bank collision and checks, against a reference array, that only port A's value landed.

// File: rtl/rf_pkg.sv
package rf_pkg;
    // Bank index, taken from bit 0 of a register number.
    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;

    function automatic bank_e bank_of(input logic lsb);
        return bank_e'(lsb);
    endfunction
endpackage

// File: rtl/rf_sdp_mem.sv
// One write port, one synchronous read port; a read on the write edge sees the old word.
module rf_sdp_mem #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/rf_bank.sv
// One bank: NRD identical copies sharing a single write port.
module rf_bank #(
    parameter int DW  = 32,
    parameter int AW  = 5,
    parameter int NRD = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    for (genvar c = 0; c < NRD; c++) begin : g_copy
        rf_sdp_mem #(
            .DW (DW),
            .AW (AW)
        ) mem_i (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr[c]),
            .rdata (rdata[c])
        );
    end
endmodule

// File: rtl/rf_wr_route.sv
// Steers the two write ports onto the two banks by address parity; port A wins a bank.
module rf_wr_route #(
    parameter int DW      = 32,
    parameter int ADDR_W  = 5,
    parameter int BANK_AW = 4
) (
    input  logic                    wa_en,
    input  logic [ADDR_W-1:0]       wa_addr,
    input  logic [DW-1:0]           wa_data,
    input  logic                    wb_en,
    input  logic [ADDR_W-1:0]       wb_addr,
    input  logic [DW-1:0]           wb_data,
    output logic [1:0]              bank_we,
    output logic [1:0][BANK_AW-1:0] bank_waddr,
    output logic [1:0][DW-1:0]      bank_wdata,
    output logic                    violation
);
    import rf_pkg::*;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic a_hit, b_hit;
        always_comb begin
            a_hit         = wa_en && (wa_addr[0] == 1'(b));
            b_hit         = wb_en && (wb_addr[0] == 1'(b));
            bank_we[b]    = a_hit || b_hit;
            bank_waddr[b] = a_hit ? wa_addr[ADDR_W-1:1] : wb_addr[ADDR_W-1:1];
            bank_wdata[b] = a_hit ? wa_data : wb_data;
        end
    end

    always_comb begin
        violation = (wa_en && (bank_of(wa_addr[0]) == BANK_ODD))
                 || (wb_en && (bank_of(wb_addr[0]) == BANK_EVEN))
                 || (wa_en && wb_en && (wa_addr[0] == wb_addr[0]));
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int NUM_SETS = 2,
    parameter int NUM_RD   = 4,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SET_W-1:0]              set_sel,
    input  logic                          wa_en,
    input  logic [ADDR_W-1:0]             wa_addr,
    input  logic [DATA_W-1:0]             wa_data,
    input  logic                          wb_en,
    input  logic [ADDR_W-1:0]             wb_addr,
    input  logic [DATA_W-1:0]             wb_data,
    input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data,
    input  logic                          conflict_clr,
    output logic                          conflict
);
    localparam int BANK_AW = ADDR_W - 1;
    localparam int MEM_AW  = BANK_AW + SET_W;

    typedef struct packed {
        logic              conflict;
        logic [NUM_RD-1:0] rd_odd;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]                          bank_we;
    logic [1:0][BANK_AW-1:0]             bank_waddr;
    logic [1:0][DATA_W-1:0]              bank_wdata;
    logic                                violation;
    logic [NUM_RD-1:0][MEM_AW-1:0]       mem_raddr;
    logic [1:0][NUM_RD-1:0][DATA_W-1:0]  bank_rd;

    rf_wr_route #(
        .DW      (DATA_W),
        .ADDR_W  (ADDR_W),
        .BANK_AW (BANK_AW)
    ) route_i (
        .wa_en      (wa_en),
        .wa_addr    (wa_addr),
        .wa_data    (wa_data),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .bank_we    (bank_we),
        .bank_waddr (bank_waddr),
        .bank_wdata (bank_wdata),
        .violation  (violation)
    );

    for (genvar i = 0; i < NUM_RD; i++) begin : g_raddr
        assign mem_raddr[i] = {set_sel, rd_addr[i][ADDR_W-1:1]};
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        rf_bank #(
            .DW  (DATA_W),
            .AW  (MEM_AW),
            .NRD (NUM_RD)
        ) bank_i (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr ({set_sel, bank_waddr[b]}),
            .wdata (bank_wdata[b]),
            .raddr (mem_raddr),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.conflict = (st_q.conflict && !conflict_clr) || violation;
        for (int i = 0; i < NUM_RD; i++) begin
            st_d.rd_odd[i] = rd_addr[i][0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NUM_RD; i++) begin : g_rmux
        assign rd_data[i] = st_q.rd_odd[i] ? bank_rd[1][i] : bank_rd[0][i];
    end

    assign conflict = st_q.conflict;
endmodule

// File: rtl/rf_chk.sv
module rf_chk (
    input logic clk,
    input logic rst_n,
    input logic wa_en,
    input logic wa_lsb,
    input logic wb_en,
    input logic wb_lsb,
    input logic conflict_clr,
    input logic conflict
);
    // R6
    bank_clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && (wa_lsb == wb_lsb)) |=> conflict);

    // R7
    wrong_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wa_en && wa_lsb) || (wb_en && !wb_lsb)) |=> conflict);

    // R8
    conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && !conflict_clr) |=> conflict);

    // R8
    conflict_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_clr && !wa_en && !wb_en) |=> !conflict);

    // R8
    conflict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conflict) |-> $past((wa_en && wa_lsb) || (wb_en && !wb_lsb)
                                 || (wa_en && wb_en && (wa_lsb == wb_lsb))));

    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_flag_chk: assert (!conflict);
        end
    end
endmodule

bind banked_regfile rf_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wa_en        (wa_en),
    .wa_lsb       (wa_addr[0]),
    .wb_en        (wb_en),
    .wb_lsb       (wb_addr[0]),
    .conflict_clr (conflict_clr),
    .conflict     (conflict)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NR = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [0:0]            set_sel = '0;
    logic                  wa_en = 1'b0, wb_en = 1'b0;
    logic [AW-1:0]         wa_addr = '0, wb_addr = '0;
    logic [DW-1:0]         wa_data = '0, wb_data = '0;
    logic [NR-1:0][AW-1:0] rd_addr = '0;
    logic [NR-1:0][DW-1:0] rd_data;
    logic                  conflict_clr = 1'b0;
    logic                  conflict;

    banked_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .set_sel(set_sel),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .conflict_clr(conflict_clr), .conflict(conflict)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] refm [2][32];

    typedef struct packed {
        logic          set;
        logic          ae;
        logic [AW-1:0] aa;
        logic [DW-1:0] ad;
        logic          be;
        logic [AW-1:0] ba;
        logic [DW-1:0] bd;
        logic          conf;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 5'd2,  32'h1111_0002, 1'b1, 5'd3,  32'h2222_0003, 1'b0}, // R2
        '{1'b1, 1'b1, 5'd2,  32'h3333_0002, 1'b1, 5'd3,  32'h4444_0003, 1'b0}, // R5
        '{1'b0, 1'b1, 5'd8,  32'h5555_0008, 1'b1, 5'd10, 32'h6666_000A, 1'b1}, // R6 even clash
        '{1'b0, 1'b1, 5'd7,  32'h7777_0007, 1'b0, 5'd0,  32'h0,         1'b1}, // R7 A odd
        '{1'b1, 1'b0, 5'd0,  32'h0,         1'b1, 5'd12, 32'h8888_000C, 1'b1}, // R7 B even
        '{1'b0, 1'b1, 5'd30, 32'h9999_001E, 1'b1, 5'd31, 32'hAAAA_001F, 1'b0}, // R1 R2
        '{1'b1, 1'b1, 5'd5,  32'hBBBB_0005, 1'b1, 5'd9,  32'hCCCC_0009, 1'b1}, // R6 odd clash
        '{1'b0, 1'b0, 5'd0,  32'h0,         1'b0, 5'd0,  32'h0,         1'b0}  // idle
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        wa_en = 1'b0; wb_en = 1'b0; conflict_clr = 1'b0;
    endtask

    task automatic mwrite(input int s, input logic ae, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                          input logic be, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
        if (ae) refm[s][aa] = ad;
        if (be && !(ae && (aa[0] == ba[0]))) refm[s][ba] = bd;
    endtask

    task automatic write2(input int s, input logic ae, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                          input logic be, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                          input logic clr);
        set_sel = 1'(s);
        wa_en = ae; wa_addr = aa; wa_data = ad;
        wb_en = be; wb_addr = ba; wb_data = bd;
        conflict_clr = clr;
        tick();
        mwrite(s, ae, aa, ad, be, ba, bd);
        quiet();
    endtask

    task automatic read4(input int s, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                         input logic [AW-1:0] a2, input logic [AW-1:0] a3,
                         input logic clr, input string req);
        logic [AW-1:0] ad [NR];
        ad[0] = a0; ad[1] = a1; ad[2] = a2; ad[3] = a3;
        set_sel = 1'(s);
        for (int i = 0; i < NR; i++) rd_addr[i] = ad[i];
        conflict_clr = clr;
        tick();
        conflict_clr = 1'b0;
        for (int i = 0; i < NR; i++) check(req, rd_data[i], refm[s][ad[i]]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 conflict in reset", 32'(conflict), 32'h0);
        rst_n = 1'b1;
        tick();
        check("R9 conflict after reset", 32'(conflict), 32'h0);

        // Fill every register of both sets with legal-parity pairs (R1 R2)
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 16; k++) begin
                write2(s, 1'b1, 5'(2*k), 32'hA000_0000 | (s << 16) | (2*k),
                          1'b1, 5'(2*k+1), 32'hB000_0000 | (s << 16) | (2*k+1), 1'b0);
            end
        end
        check("R2 no flag on legal writes", 32'(conflict), 32'h0);

        // Sweep all registers, varied port-to-address mapping (R3 R5)
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++) begin
                read4(s, 5'(4*k+3), 5'(4*k), 5'(4*k+1), 5'(4*k+2), 1'b0, "R3 R5 sweep read");
            end
        end

        // Vector table
        for (int v = 0; v < 8; v++) begin
            write2(VECS[v].set, VECS[v].ae, VECS[v].aa, VECS[v].ad,
                   VECS[v].be, VECS[v].ba, VECS[v].bd, 1'b0);
            check("R6 R7 conflict after vector", 32'(conflict), 32'(VECS[v].conf));
            read4(VECS[v].set, VECS[v].aa, VECS[v].ba, VECS[v].aa ^ 5'd1, VECS[v].ba ^ 5'd1,
                  1'b1, "R1 R6 R7 vector read");
            check("R8 cleared after vector", 32'(conflict), 32'h0);
        end

        // Both sets again after the vectors (R5)
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++) begin
                read4(s, 5'(4*k), 5'(4*k+1), 5'(4*k+2), 5'(4*k+3), 1'b0, "R5 set isolation");
            end
        end

        // Read on the write edge returns old contents (R4)
        begin
            logic [DW-1:0] old4, old5;
            old4 = refm[0][4]; old5 = refm[0][5];
            set_sel = 1'b0;
            rd_addr[0] = 5'd4; rd_addr[1] = 5'd5; rd_addr[2] = 5'd4; rd_addr[3] = 5'd5;
            wa_en = 1'b1; wa_addr = 5'd4; wa_data = 32'hDEAD_0004;
            wb_en = 1'b1; wb_addr = 5'd5; wb_data = 32'hBEEF_0005;
            tick();
            quiet();
            mwrite(0, 1'b1, 5'd4, 32'hDEAD_0004, 1'b1, 5'd5, 32'hBEEF_0005);
            check("R4 read-before-write even", rd_data[0], old4);
            check("R4 read-before-write odd", rd_data[1], old5);
            tick();
            check("R1 new even value", rd_data[2], 32'hDEAD_0004);
            check("R2 new odd value", rd_data[3], 32'hBEEF_0005);
        end

        // Write into set 1 while reading same register of set 1 on that edge (R5 R4)
        begin
            logic [DW-1:0] old20;
            old20 = refm[1][20];
            set_sel = 1'b1;
            rd_addr[0] = 5'd20;
            wa_en = 1'b1; wa_addr = 5'd20; wa_data = 32'h5E71_0014;
            tick();
            quiet();
            mwrite(1, 1'b1, 5'd20, 32'h5E71_0014, 1'b0, 5'd0, 32'h0);
            check("R4 R5 set1 old value", rd_data[0], old20);
            read4(1, 5'd20, 5'd20, 5'd21, 5'd20, 1'b0, "R5 set1 new value");
            read4(0, 5'd20, 5'd21, 5'd20, 5'd21, 1'b0, "R5 set0 untouched");
        end

        // Sticky flag behaviour (R8)
        write2(0, 1'b1, 5'd2, 32'hC0DE_0002, 1'b1, 5'd4, 32'hBAD0_0004, 1'b0);
        check("R6 clash sets flag", 32'(conflict), 32'h1);
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R8 flag holds", 32'(conflict), 32'h1);
        end
        write2(0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd6, 32'hF00D_0006, 1'b1);
        check("R8 breach beats clear", 32'(conflict), 32'h1);
        conflict_clr = 1'b1;
        tick();
        conflict_clr = 1'b0;
        check("R8 clear alone", 32'(conflict), 32'h0);
        tick();
        check("R8 stays clear", 32'(conflict), 32'h0);
        read4(0, 5'd2, 5'd4, 5'd6, 5'd3, 1'b0, "R6 R7 sticky-phase data");

        // Reset mid-run clears the flag (R9)
        write2(0, 1'b1, 5'd1, 32'h1, 1'b0, 5'd0, 32'h0, 1'b0);
        check("R7 flag before reset", 32'(conflict), 32'h1);
        mwrite(0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0);
        rst_n = 1'b0;
        #3;
        check("R9 flag in reset", 32'(conflict), 32'h0);
        tick();
        rst_n = 1'b1;
        tick();
        check("R9 flag after release", 32'(conflict), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule